// File: doc/BRIEF.md
# I2C Target Register Read Engine

This block is an I2C target that lets a bus master read a bank of 8-bit registers held outside the block. It runs on a system clock much faster than SCL. Both bus lines pass through two-flop synchronizers and a run-length filter. The filtered lines feed a detector that recognises START, repeated START and STOP conditions and the rising and falling edges of SCL. A control machine then decodes the 7-bit address byte and performs one of two transfers:

- A write transfer carries a single register index, which presets the read pointer.
- A read transfer shifts out register contents, most significant bit first. The pointer steps after every byte and wraps at the end of the bank.

The block drives SDA through an open-drain enable: `sda_oe` high means pull the line low.

Register contents arrive on a plain parallel read port. The block shows the pointer on `rd_idx` and expects `rd_data` to hold that register's value in the same cycle. The port has no valid/ready handshake and applies no back-pressure. The bus clock paces every transfer, and the bank must answer without waiting states. Where a read starts depends on how the frame began:

- After a plain START, the read starts at register 0.
- After a repeated START that directly follows a pointer-setting write, the read starts at the preset index.

Top module: `i2c_regread_tgt`

## Requirements
- R1: When the address byte's upper seven bits equal the `TGT_ADDR` parameter, the target pulls SDA low for the whole 9th SCL pulse of that byte, whatever the R/W bit (bit 0) is.
- R2: When the address does not match, the target pulls SDA low at no time until the next START or STOP. This covers the acknowledge slot and any bytes the master clocks afterwards. The read pointer keeps its value.
- R3: A read (R/W bit 1) that begins with a plain START returns register 0 first. This holds also when the bus was idle after a STOP.
- R4: The pointer advances by one after each transmitted byte and wraps from `NREGS-1` to 0. Successive bytes of one read therefore come from successive registers.
- R5: In a write (R/W bit 0), the target acknowledges the first data byte and takes it, modulo `NREGS`, as the new pointer. It acknowledges no later data byte in that frame.
- R6: A read that starts with a repeated START straight after a pointer-setting write returns the preset register first.
- R7: Read data is sent most significant bit first. The target changes SDA only while SCL is low, so SDA is steady for the whole time SCL is high.
- R8: When the master answers a byte with a not-acknowledge (SDA high on the 9th pulse), the target releases SDA. It sends nothing more until a new START.
- R9: A preset is discarded by a STOP and by any later START. A read after STOP-then-START, or a read after a repeated START that follows a read frame, begins at register 0.
- R10: During and right after reset, SDA is released and `rd_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | High to pull SDA low (open drain) |
| rd_idx | output | $clog2(NREGS) | Register index being read |
| rd_data | input | 8 | Contents of register `rd_idx`, valid in the same cycle |

## Verification
Register values differ from one index to the next, so any returned byte reveals which register it came from. Reads are tried after the following, which separates the three pointer-start rules:

- a plain START;
- a pointer write followed by a repeated START;
- a pointer write followed by STOP and START;
- a read frame followed by a repeated START.

A preset near the end of the bank and an index larger than the bank exercise the wrap and the modulo. Wrong-address frames, bytes clocked after a not-acknowledge, and extra write data check silence on SDA. A per-clock monitor compares the drive enable against the SCL-high rule.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WIDX, ST_WACK, ST_RBIT, ST_RACK, ST_SKIP
  } tgt_st_e;
endpackage

// File: rtl/i2c_rr_filt.sv
// Synchronizer plus run-length filter: the output follows the line only
// after FILT identical synchronized samples.
module i2c_rr_filt #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  logic [1:0]      sy;
  logic [FILT-1:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy    <= 2'b11;
      win   <= '1;
      clean <= 1'b1;
    end else begin
      sy  <= {sy[0], raw};
      win <= {win[FILT-2:0], sy[1]};
      if (&win)       clean <= 1'b1;
      else if (~|win) clean <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_rr_cond.sv
// Bus event detector on the filtered lines.
module i2c_rr_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
endmodule

// File: rtl/i2c_rr_fsm.sv
// Byte framing, address decode, pointer rules and read shifting.
module i2c_rr_fsm
  import i2c_rr_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h2A,
  parameter int         NREGS    = 32,
  parameter int         PW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic [PW-1:0] ptr
);
  tgt_st_e       st;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic          rw, mack;
  logic          busy;   // START seen, no STOP since
  logic          armed;  // pointer written in the current frame
  logic          live;   // current START is repeated and follows a pointer write
  logic [PW-1:0] nxt;

  assign nxt = (ptr == PW'(NREGS - 1)) ? '0 : ptr + PW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; ptr <= '0;
      rw <= 1'b0; mack <= 1'b0; busy <= 1'b0; armed <= 1'b0; live <= 1'b0;
    end else if (start_ev) begin
      st    <= ST_ADDR;
      cnt   <= '0;
      live  <= armed & busy;
      armed <= 1'b0;
      busy  <= 1'b1;
    end else if (stop_ev) begin
      st    <= ST_IDLE;
      busy  <= 1'b0;
      armed <= 1'b0;
      live  <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WIDX: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (st == ST_WIDX) begin
              ptr   <= PW'(sh % 8'(NREGS));
              armed <= 1'b1;
              st    <= ST_WACK;
            end else if (sh[7:1] == TGT_ADDR) begin
              rw <= sh[0];
              if (sh[0] && !live) ptr <= '0;
              st <= ST_AACK;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt <= '0;
          if (rw) begin
            sh <= rd_data;
            st <= ST_RBIT;
          end else begin
            st <= ST_WIDX;
          end
        end
        ST_WACK: if (scl_fall) st <= ST_SKIP;
        ST_RBIT: if (scl_fall) begin
          if (cnt == 4'd7) begin
            ptr <= nxt;
            st  <= ST_RACK;
          end else begin
            sh  <= {sh[6:0], 1'b0};
            cnt <= cnt + 4'd1;
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda;
          else if (scl_fall) begin
            if (mack) begin
              sh  <= rd_data;
              cnt <= '0;
              st  <= ST_RBIT;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_AACK, ST_WACK: sda_oe = 1'b1;
      ST_RBIT:          sda_oe = ~sh[7];
      default:          sda_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_regread_tgt.sv
module i2c_regread_tgt #(
  parameter logic [6:0] TGT_ADDR = 7'h2A,
  parameter int         NREGS    = 32,
  parameter int         FILT     = 3,
  localparam int        PW       = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [PW-1:0] rd_idx,
  input  logic [7:0]    rd_data
);
  logic [1:0] raw_ln, flt_ln;
  logic       scl_f, sda_f;
  logic       start_ev, stop_ev, scl_rise, scl_fall;

  assign raw_ln = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_rr_filt #(.FILT(FILT)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_ln[g]), .clean(flt_ln[g])
    );
  end

  assign scl_f = flt_ln[0];
  assign sda_f = flt_ln[1];

  i2c_rr_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_rr_fsm #(.TGT_ADDR(TGT_ADDR), .NREGS(NREGS), .PW(PW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda(sda_f),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr(rd_idx)
  );
endmodule

// File: rtl/i2c_regread_tgt_chk.sv
module i2c_regread_tgt_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic start_ev,
  input logic stop_ev,
  input logic scl_rise,
  input logic scl_fall,
  input logic sda_oe
);
  // R7: drive enable holds while filtered SCL stays high
  p_sda_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  // R7: bus events are mutually exclusive
  p_cond_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, stop_ev, scl_rise, scl_fall}));

  // R8: a START leaves SDA released
  p_free_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

  // R9: a STOP leaves SDA released
  p_free_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
endmodule

bind i2c_regread_tgt i2c_regread_tgt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_ev(start_ev),
  .stop_ev(stop_ev), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .sda_oe(sda_oe)
);

// File: tb/i2c_regread_tgt_tb.sv
`timescale 1ns/1ps
module i2c_regread_tgt_tb;
  localparam logic [6:0] ADR = 7'h2A;
  localparam int NR = 32;
  localparam int Q  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [4:0] rd_idx;
  logic [7:0] rd_data;
  wire sda_bus = ~(m_low | sda_oe);

  int checks = 0, failures = 0;
  bit done = 0;
  // behavioural model of the pointer rules
  int  ptr_m = 0;
  bit  busy_m = 0, armed_m = 0, live_m = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] regv(int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  assign rd_data = regv(int'(rd_idx));

  i2c_regread_tgt u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R7 per-clock monitor: enable steady while raw SCL high
  logic scl_p = 1'b1, oe_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_m && scl_p) chk(sda_oe == oe_p, "R7 oe change during SCL high", sda_oe, oe_p);
    end
    scl_p <= scl_m;
    oe_p  <= sda_oe;
  end

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wbit(input bit b);
    m_low = ~b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic rbit(output bit b);
    bit b0;
    m_low = 1'b0; qw(); scl_m = 1'b1; qw(); b0 = sda_bus; qw(); b = sda_bus;
    chk(b0 == b, "R7 SDA stable while SCL high", b, b0);
    scl_m = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(ack);
  endtask

  task automatic rbyte(output logic [7:0] v, input bit nack);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(nack);
  endtask

  task automatic m_start();
    m_low = 1'b1; qw(); scl_m = 1'b0; qw();
    live_m = armed_m && busy_m; armed_m = 0; busy_m = 1;
  endtask

  task automatic m_rstart();
    m_low = 1'b0; qw(); scl_m = 1'b1; qw(); m_low = 1'b1; qw(); scl_m = 1'b0; qw();
    live_m = armed_m && busy_m; armed_m = 0; busy_m = 1;
  endtask

  task automatic m_stop();
    m_low = 1'b1; qw(); scl_m = 1'b1; qw(); m_low = 1'b0; qw(); qw();
    busy_m = 0; armed_m = 0;
  endtask

  task automatic set_ptr(input int idx);
    bit a;
    m_start();
    wbyte({ADR, 1'b0}, a);
    chk(a == 0, "R1 write address ack", a, 0);
    wbyte(8'(idx), a);
    chk(a == 0, "R5 index ack", a, 0);
    ptr_m = idx % NR; armed_m = 1;
  endtask

  task automatic read_n(input bit rep, input int n, input string req);
    bit a;
    logic [7:0] v;
    if (rep) m_rstart(); else m_start();
    wbyte({ADR, 1'b1}, a);
    chk(a == 0, "R1 read address ack", a, 0);
    if (!live_m) ptr_m = 0;
    for (int k = 0; k < n; k++) begin
      rbyte(v, k == n - 1);
      chk(v == regv(ptr_m), req, v, regv(ptr_m));
      ptr_m = (ptr_m + 1) % NR;
    end
  endtask

  initial begin
    bit a;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0, "R10 SDA released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(sda_oe == 0 && rd_idx == 0, "R10 idle after reset", {sda_oe, rd_idx}, 0);

    read_n(0, 3, "R3 R4 plain read from 0");
    m_stop();

    set_ptr(5);
    read_n(1, 2, "R6 preset read");
    m_stop();

    set_ptr(9);
    m_stop();
    read_n(0, 1, "R9 preset lost after STOP");
    read_n(1, 2, "R9 rstart after read frame from 0");
    m_stop();

    set_ptr(30);
    read_n(1, 4, "R4 wrap");
    m_stop();

    set_ptr(40);
    read_n(1, 1, "R5 index modulo");
    m_stop();

    // R5: further write data not acknowledged
    set_ptr(3);
    wbyte(8'h55, a);
    chk(a == 1, "R5 data byte not acked", a, 1);
    m_stop();

    // R2: wrong address ignored
    m_start();
    wbyte({7'h13, 1'b1}, a);
    chk(a == 1, "R2 mismatch no ack", a, 1);
    rbyte(v, 1);
    chk(v == 8'hFF, "R2 silent after mismatch", v, 8'hFF);
    m_stop();
    set_ptr(12);
    m_stop();
    m_start();
    wbyte({7'h2B, 1'b0}, a);
    chk(a == 1, "R2 mismatch write no ack", a, 1);
    wbyte(8'h01, a);
    chk(a == 1, "R2 no ack for data", a, 1);
    m_stop();
    read_n(0, 1, "R3 read from 0 after idle");

    // R8: nothing sent after NACK
    rbyte(v, 1);
    chk(v == 8'hFF, "R8 silent after NACK", v, 8'hFF);
    m_stop();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule